// File: doc/BRIEF.md
# Pseudo-Conversion ADC Register Block

This block is the software-visible register file of a single analog-to-digital converter. It has no analog front end. A deterministic pseudo-conversion source stands in for one: each conversion adds a fixed step to a hidden accumulator. The result is then cut down to the resolution selected in the first control register. It can also be shifted into a left-aligned form before it is returned. A conversion is not a background process. It happens only when the regular data register is read while the converter is enabled and a software start is pending. That read also consumes the start request.

The bus is a plain 32-bit word interface. A request is accepted in the cycle it is presented, and byte offsets cover a 256-byte window. Read data is registered and appears one clock after the request. The block holds the following registers:

- a status register whose bits can only be cleared by writes
- two control registers
- two sample-time registers
- injected-channel offset and data registers
- high and low watchdog thresholds
- four sequence registers
- the regular data register

An access to an offset the block does not decode returns zero, leaves all state unchanged and raises a one-cycle error flag.

Top module: `pseudo_adc_regs`

## Requirements
- R1: After reset every register reads as zero, except the high watchdog threshold at offset 0x24, which reads 0x00000FFF.
- R2: These registers read back exactly the 32-bit value last written, with no side effects: the first control register 0x04, the sample-time registers 0x0C and 0x10, the high threshold 0x24, the low threshold 0x28, the sequence registers 0x2C, 0x30 and 0x34, and the injected sequence register 0x38. The second control register at 0x08 also stores all 32 written bits.
- R3: A write to the status register at 0x00 replaces its value with the old value ANDed with bits 5:0 of the written data, so a write can only clear status bits.
- R4: A read of the regular data register at 0x4C starts a conversion only when control-2 bit 0 (enable) and control-2 bit 30 (software start) are both 1. That read returns the new sample and clears bit 30. Any other read of 0x4C returns zero and changes nothing. Writes to 0x4C are ignored and raise no error.
- R5: Each conversion sets the accumulator, which starts at zero, to (accumulator + 7) masked by the field in control-1 bits 25:24. The field values keep 12 bits for 0, 10 bits for 1, 8 bits for 2 and 6 bits for 3.
- R6: When control-2 bit 11 is 1, the returned sample is (accumulator << 1) AND 0xFFF0. When bit 11 is 0, the sample is the masked accumulator itself.
- R7: A read of control-2 at 0x08 returns bits 27:0 of the stored value, with bits 31:28 reading as zero.
- R8: The four injected offset registers at 0x14, 0x18, 0x1C and 0x20 keep only bits 11:0 of the written data.
- R9: The four injected data registers at 0x3C, 0x40, 0x44 and 0x48 store all 32 bits when written. A read of data register n returns the stored value minus offset register n, modulo 2^32.
- R10: An access at offset 0x100 or above, at an offset that is not a multiple of four, or at a word offset from 0x50 to 0xFC reads zero and changes no register. The error output is 1 in the cycle after such a request and 0 in the cycle after any other cycle.
- R11: Read data appears on the data output in the clock cycle after the request. In the cycle after a write or an idle cycle, the data output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transfer request, accepted in the same cycle |
| wr | input | 1 | 1 for a write, 0 for a read |
| addr | input | ADDR_W (12) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after a read request |
| err | output | 1 | One-cycle flag for an undecoded access |

## Verification
The checker watches several properties on every cycle. Status bits never rise. A conversion always clears the start bit and leaves the accumulator inside the selected resolution. Left-aligned samples have empty low nibbles and upper halves. The upper control-2 bits always read as zero. Idle reads of the data register return zero. Writes and idle cycles leave the data output at zero. The error flag follows exactly the undecoded requests. Other behaviours need the bench's scenarios because they depend on the history of what was written: the exact accumulator sequence across resolution changes, the subtraction on injected reads, the reset values, and proof that an undecoded write leaves every register unchanged.

// File: rtl/pseudo_adc_pkg.sv
package pseudo_adc_pkg;

  localparam int unsigned DW     = 32;
  localparam int unsigned ACC_W  = 12;
  localparam int unsigned STAT_W = 6;
  localparam int unsigned OFS_W  = 12;

  // control-2 bit positions, control-1 resolution field position
  localparam int unsigned B_ON    = 0;
  localparam int unsigned B_ALIGN = 11;
  localparam int unsigned B_START = 30;
  localparam int unsigned B_RES   = 24;

  localparam logic [DW-1:0] WDHI_RST = 32'h0000_0FFF;

  typedef struct packed {
    logic stat;
    logic ctla;
    logic ctlb;
    logic smpa;
    logic smpb;
    logic iofs;
    logic wdhi;
    logic wdlo;
    logic seqa;
    logic seqb;
    logic seqc;
    logic iseq;
    logic idat;
    logic rdat;
  } hit_t;

  function automatic logic [ACC_W-1:0] res_mask(input logic [1:0] r);
    case (r)
      2'd0:    return 12'hFFF;
      2'd1:    return 12'h3FF;
      2'd2:    return 12'h0FF;
      default: return 12'h03F;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] conv_next(input logic [ACC_W-1:0] a,
                                                 input logic [1:0] r,
                                                 input logic [ACC_W-1:0] step);
    return (a + step) & res_mask(r);
  endfunction

  function automatic logic [DW-1:0] place_sample(input logic [ACC_W-1:0] a,
                                                 input logic left);
    logic [DW-1:0] w;
    w = {{(DW-ACC_W){1'b0}}, a};
    return left ? ((w << 1) & 32'h0000_FFF0) : w;
  endfunction

endpackage

// File: rtl/padc_decode.sv
module padc_decode
  import pseudo_adc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 256,
  parameter int N_INJ        = 4
) (
  input  logic [ADDR_W-1:0]                     addr,
  output hit_t                                  hit,
  output logic [((N_INJ > 1) ? $clog2(N_INJ) : 1)-1:0] inj,
  output logic                                  known
);
  localparam int INJ_W  = (N_INJ > 1) ? $clog2(N_INJ) : 1;
  localparam int I_IOFS = 5;
  localparam int I_WDHI = I_IOFS + N_INJ;
  localparam int I_WDLO = I_WDHI + 1;
  localparam int I_SEQA = I_WDLO + 1;
  localparam int I_ISEQ = I_SEQA + 3;
  localparam int I_IDAT = I_ISEQ + 1;
  localparam int I_RDAT = I_IDAT + N_INJ;

  logic in_win;
  int   idx;

  always_comb begin
    hit    = '0;
    inj    = '0;
    in_win = (32'(addr) < 32'(WINDOW_BYTES)) && (addr[1:0] == 2'b00);
    idx    = int'(32'(addr) >> 2);
    if (in_win) begin
      if (idx == 0)                              hit.stat = 1'b1;
      else if (idx == 1)                         hit.ctla = 1'b1;
      else if (idx == 2)                         hit.ctlb = 1'b1;
      else if (idx == 3)                         hit.smpa = 1'b1;
      else if (idx == 4)                         hit.smpb = 1'b1;
      else if (idx >= I_IOFS && idx < I_WDHI) begin
        hit.iofs = 1'b1;
        inj      = INJ_W'(idx - I_IOFS);
      end
      else if (idx == I_WDHI)                    hit.wdhi = 1'b1;
      else if (idx == I_WDLO)                    hit.wdlo = 1'b1;
      else if (idx == I_SEQA)                    hit.seqa = 1'b1;
      else if (idx == I_SEQA + 1)                hit.seqb = 1'b1;
      else if (idx == I_SEQA + 2)                hit.seqc = 1'b1;
      else if (idx == I_ISEQ)                    hit.iseq = 1'b1;
      else if (idx >= I_IDAT && idx < I_RDAT) begin
        hit.idat = 1'b1;
        inj      = INJ_W'(idx - I_IDAT);
      end
      else if (idx == I_RDAT)                    hit.rdat = 1'b1;
    end
    known = |hit;
  end
endmodule

// File: rtl/padc_sample_gen.sv
module padc_sample_gen
  import pseudo_adc_pkg::*;
#(
  parameter int STEP = 7
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [1:0]       res,
  input  logic             left,
  output logic [ACC_W-1:0] acc_next,
  output logic [DW-1:0]    sample
);
  assign acc_next = conv_next(acc_q, res, ACC_W'(STEP));
  assign sample   = place_sample(acc_next, left);
endmodule

// File: rtl/pseudo_adc_regs.sv
module pseudo_adc_regs
  import pseudo_adc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 256,
  parameter int N_INJ        = 4,
  parameter int STEP         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int INJ_W = (N_INJ > 1) ? $clog2(N_INJ) : 1;

  hit_t             hit;
  logic [INJ_W-1:0] inj;
  logic             known;

  logic [STAT_W-1:0] stat_q;
  logic [DW-1:0]     ctla_q, ctlb_q, smpa_q, smpb_q, wdhi_q, wdlo_q;
  logic [DW-1:0]     seqa_q, seqb_q, seqc_q, iseq_q;
  logic [ACC_W-1:0]  acc_q, acc_next;
  logic [DW-1:0]     sample, rd_mux, rdata_q;
  logic              err_q;

  logic [OFS_W-1:0]  iofs_v [N_INJ];
  logic [DW-1:0]     idat_v [N_INJ];

  // named internal events
  logic       rd_en, wr_en, conv_fire, hit_rdat, hit_ctlb;
  logic [1:0] res_sel;

  assign rd_en     = req & ~wr;
  assign wr_en     = req & wr;
  assign hit_rdat  = hit.rdat;
  assign hit_ctlb  = hit.ctlb;
  assign res_sel   = ctla_q[B_RES+1:B_RES];
  assign conv_fire = rd_en & hit.rdat & ctlb_q[B_ON] & ctlb_q[B_START];

  padc_decode #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES), .N_INJ(N_INJ)) u_dec (
    .addr(addr), .hit(hit), .inj(inj), .known(known)
  );

  padc_sample_gen #(.STEP(STEP)) u_gen (
    .acc_q(acc_q), .res(res_sel), .left(ctlb_q[B_ALIGN]),
    .acc_next(acc_next), .sample(sample)
  );

  for (genvar i = 0; i < N_INJ; i++) begin : g_inj
    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q <= '0;
        dat_q <= '0;
      end else if (wr_en && inj == INJ_W'(i)) begin
        if (hit.iofs) ofs_q <= wdata[OFS_W-1:0];
        if (hit.idat) dat_q <= wdata;
      end
    end
    assign iofs_v[i] = ofs_q;
    assign idat_v[i] = dat_q;
  end

  always_comb begin
    rd_mux = '0;
    if (hit.stat)      rd_mux = {{(DW-STAT_W){1'b0}}, stat_q};
    else if (hit.ctla) rd_mux = ctla_q;
    else if (hit.ctlb) rd_mux = {4'b0000, ctlb_q[27:0]};
    else if (hit.smpa) rd_mux = smpa_q;
    else if (hit.smpb) rd_mux = smpb_q;
    else if (hit.iofs) rd_mux = {{(DW-OFS_W){1'b0}}, iofs_v[inj]};
    else if (hit.wdhi) rd_mux = wdhi_q;
    else if (hit.wdlo) rd_mux = wdlo_q;
    else if (hit.seqa) rd_mux = seqa_q;
    else if (hit.seqb) rd_mux = seqb_q;
    else if (hit.seqc) rd_mux = seqc_q;
    else if (hit.iseq) rd_mux = iseq_q;
    else if (hit.idat) rd_mux = idat_v[inj] - {{(DW-OFS_W){1'b0}}, iofs_v[inj]};
    else if (hit.rdat) rd_mux = conv_fire ? sample : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ctla_q  <= '0;
      ctlb_q  <= '0;
      smpa_q  <= '0;
      smpb_q  <= '0;
      wdhi_q  <= WDHI_RST;
      wdlo_q  <= '0;
      seqa_q  <= '0;
      seqb_q  <= '0;
      seqc_q  <= '0;
      iseq_q  <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= req & ~known;
      rdata_q <= rd_en ? rd_mux : '0;
      if (wr_en) begin
        if (hit.stat) stat_q <= stat_q & wdata[STAT_W-1:0];
        if (hit.ctla) ctla_q <= wdata;
        if (hit.ctlb) ctlb_q <= wdata;
        if (hit.smpa) smpa_q <= wdata;
        if (hit.smpb) smpb_q <= wdata;
        if (hit.wdhi) wdhi_q <= wdata;
        if (hit.wdlo) wdlo_q <= wdata;
        if (hit.seqa) seqa_q <= wdata;
        if (hit.seqb) seqb_q <= wdata;
        if (hit.seqc) seqc_q <= wdata;
        if (hit.iseq) iseq_q <= wdata;
      end
      if (conv_fire) begin
        acc_q           <= acc_next;
        ctlb_q[B_START] <= 1'b0;
      end
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/pseudo_adc_regs_chk.sv
module pseudo_adc_regs_chk
  import pseudo_adc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wr,
  input logic              err,
  input logic [31:0]       rdata,
  input logic [STAT_W-1:0] stat_q,
  input logic [DW-1:0]     ctlb_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [1:0]        res_sel,
  input logic              conv_fire,
  input logic              known,
  input logic              hit_rdat,
  input logic              hit_ctlb
);
  // R3: status bits never rise
  p_stat_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q)) == '0));

  // R4: a conversion consumes the start request
  p_start_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire |=> !ctlb_q[B_START]);

  // R4: a data read without a pending start returns zero
  p_idle_rdat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && hit_rdat && !conv_fire) |=> (rdata == '0));

  // R5: the accumulator stays within the resolution in force at the conversion
  p_acc_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire |=> ((acc_q & ~res_mask($past(res_sel))) == '0));

  // R6: left-aligned samples have an empty low nibble and upper half
  p_aligned_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fire && ctlb_q[B_ALIGN]) |=> (rdata[3:0] == 4'h0 && rdata[31:16] == 16'h0));

  // R7: control-2 reads hide the top nibble
  p_ctlb_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && hit_ctlb) |=> (rdata[31:28] == 4'h0));

  // R10: error flag follows undecoded requests
  p_err_on_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !known) |=> err);
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || known) |=> !err);

  // R11: writes and idle cycles leave the data output at zero
  p_no_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || wr) |=> (rdata == '0));
endmodule

bind pseudo_adc_regs pseudo_adc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .err(err), .rdata(rdata),
  .stat_q(stat_q), .ctlb_q(ctlb_q), .acc_q(acc_q), .res_sel(res_sel),
  .conv_fire(conv_fire), .known(known), .hit_rdat(hit_rdat), .hit_ctlb(hit_ctlb)
);

// File: tb/pseudo_adc_regs_tb_top.sv
`timescale 1ns/1ps
module pseudo_adc_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m [20];
  logic [31:0] macc;

  always #10 clk = ~clk;

  pseudo_adc_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err)
  );

  function automatic logic [31:0] tb_mask(input logic [1:0] r);
    return 32'h0000_0FFF >> (2 * r);
  endfunction

  function automatic bit tb_bad(input logic [11:0] a);
    return (a >= 12'h100) || (a[1:0] != 2'b00) || (a[7:2] > 6'd19);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 20; i++) m[i] = '0;
    m[9] = 32'h0000_0FFF;
    macc = '0;
  endtask

  task automatic model_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    int k;
    d = '0;
    e = tb_bad(a);
    if (e) return;
    k = int'(a[7:2]);
    if (k == 2)                 d = m[2] & 32'h0FFF_FFFF;
    else if (k >= 15 && k <= 18) d = m[k] - m[k-10];
    else if (k == 19) begin
      if (m[2][0] && m[2][30]) begin
        macc    = (macc + 32'd7) & tb_mask(m[1][25:24]);
        m[2][30] = 1'b0;
        d = m[2][11] ? ((macc * 2) & 32'h0000_FFF0) : macc;
      end
    end
    else d = m[k];
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] w, output logic e);
    int k;
    e = tb_bad(a);
    if (e) return;
    k = int'(a[7:2]);
    if (k == 0)                 m[0] = m[0] & {26'd0, w[5:0]};
    else if (k >= 5 && k <= 8)   m[k] = w & 32'h0000_0FFF;
    else if (k != 19)            m[k] = w;
  endtask

  task automatic check32(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one transfer; outputs checked one cycle after the request (R11)
  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] ed;
    logic        ee;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    if (w) begin model_write(a, d, ee); ed = '0; end
    else   model_read(a, ed, ee);
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    check32(rdata, ed, tag);
    check32({31'd0, err}, {31'd0, ee}, {tag, "/err"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] a;
    int          op;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values of all decoded registers
    for (int i = 0; i < 20; i++) xfer(1'b0, 12'(i * 4), '0, "R1");
    // R11: idle output is zero
    @(negedge clk); check32(rdata, '0, "R11 idle");

    // R3: status cannot be set by writes
    xfer(1'b1, 12'h000, 32'hFFFF_FFFF, "R3");
    xfer(1'b0, 12'h000, '0, "R3");
    // R2: plain registers
    xfer(1'b1, 12'h024, 32'hA5A5_1234, "R2");
    xfer(1'b0, 12'h024, '0, "R2");
    xfer(1'b1, 12'h038, 32'hDEAD_BEEF, "R2");
    xfer(1'b0, 12'h038, '0, "R2");
    // R8: offset width
    xfer(1'b1, 12'h018, 32'hFFFF_FFFF, "R8");
    xfer(1'b0, 12'h018, '0, "R8");
    // R9: injected data minus offset wraps
    xfer(1'b1, 12'h040, 32'h0000_0005, "R9");
    xfer(1'b0, 12'h040, '0, "R9");
    // R7: control-2 top nibble hidden
    xfer(1'b1, 12'h008, 32'hF000_0000, "R7");
    xfer(1'b0, 12'h008, '0, "R7");
    // R4: enable only, no start -> zero
    xfer(1'b1, 12'h008, 32'h0000_0001, "R4");
    xfer(1'b0, 12'h04C, '0, "R4");
    // R4/R5: start -> 7, second read -> 0, start bit cleared
    xfer(1'b1, 12'h008, 32'h4000_0001, "R4");
    xfer(1'b0, 12'h04C, '0, "R5");
    xfer(1'b0, 12'h04C, '0, "R4");
    xfer(1'b0, 12'h008, '0, "R4");
    // R4: write to data register ignored, no error
    xfer(1'b1, 12'h04C, 32'hFFFF_FFFF, "R4");
    // R5: 6-bit resolution wraps over repeated conversions
    xfer(1'b1, 12'h004, 32'h0300_0000, "R5");
    for (int i = 0; i < 12; i++) begin
      xfer(1'b1, 12'h008, 32'h4000_0001, "R5");
      xfer(1'b0, 12'h04C, '0, "R5");
    end
    // R6: left alignment at 12-bit resolution
    xfer(1'b1, 12'h004, 32'h0000_0000, "R6");
    for (int i = 0; i < 6; i++) begin
      xfer(1'b1, 12'h008, 32'h4000_0801, "R6");
      xfer(1'b0, 12'h04C, '0, "R6");
    end
    // R10: out-of-window write must not alias control-1
    xfer(1'b1, 12'h104, 32'h1234_5678, "R10");
    xfer(1'b0, 12'h004, '0, "R10");
    xfer(1'b0, 12'h050, '0, "R10");
    xfer(1'b1, 12'h006, 32'h0000_00FF, "R10");
    xfer(1'b0, 12'h004, '0, "R10");
    xfer(1'b0, 12'hFFC, '0, "R10");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      op = int'($urandom_range(0, 9));
      a  = 12'(($urandom_range(0, 19)) * 4);
      if (op <= 3)      xfer(1'b1, a, $urandom(), "R2 rand");
      else if (op <= 5) xfer(1'b0, a, '0, "R2 rand");
      else if (op == 6) xfer(1'b1, 12'h008, ($urandom() & 32'h0000_0FFE) | 32'h4000_0001, "R4 rand");
      else if (op == 7) xfer(1'b0, 12'h04C, '0, "R5 rand");
      else if (op == 8) xfer(1'b1, 12'h004, $urandom(), "R5 rand");
      else              xfer($urandom_range(0, 1) == 1, 12'($urandom_range(80, 4095)) | 12'h0, $urandom(), "R10 rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule